// File: doc/BRIEF.md
# Greedy Cache Configuration Search Controller

This block finds a good setting for a configurable instruction cache without trying every combination. When started, it tries the candidate settings one at a time. For each candidate it drives the setting into the cache and clears the cache's hit and miss counters. It then lets a warm-up number of fetches go by and clears the counters again. After that it counts a fixed number of fetches and scores the candidate as a weighted sum of hits and misses. The lowest score wins.

The search tunes one knob at a time and fixes each knob at its winning value before moving on. Capacity is tuned first, then line length, then the number of ways. Each knob is tried from its smallest value upward. A setting the cache cannot build is skipped without being measured: the number of ways cannot exceed the number of 2 KB banks that are switched on. A setting that was already scored in an earlier knob's pass is not measured again. When the search ends, the best setting is driven to the cache and held in a result register, together with its score.

Top module: `cache_tuner`

## Requirements
- R1: After reset, `cfg_o` is zero, `busy_o`, `done_o` and `cnt_clr_o` are low, and `result_o` and `cost_o` are zero. The configuration word uses three 2-bit fields. Bits [1:0] hold capacity (0 = 2 KB, 1 = 4 KB, 2 = 8 KB). Bits [3:2] hold line length (0 = 16 B, 1 = 32 B, 2 = 64 B). Bits [5:4] hold ways (0 = direct-mapped, 1 = 2-way, 2 = 4-way). Zero is therefore the starting configuration.
- R2: The first pass measures capacity codes 0, 1 and 2 in that order, with line code 0 and ways code 0.
- R3: The second pass keeps the winning capacity and measures line codes 1 and 2 in that order. Line code 0 keeps the score it got in the first pass.
- R4: The third pass keeps the winning capacity and line length and measures ways codes 1 and 2 in that order. Ways code 0 is not measured again. A candidate whose ways code is greater than its capacity code is skipped without measuring. `cfg_o` never shows such a setting while busy.
- R5: A candidate's score is hits × `hit_wt_i` + misses × `miss_wt_i`. It is taken from the counter inputs once hits + misses reaches `window_i`.
- R6: A candidate replaces the current best only if its score is strictly lower. On a tie, the earlier candidate is kept.
- R7: For each measured candidate, `cnt_clr_o` is high for one cycle as the setting is applied. After hits + misses reaches `warmup_i`, it is high for exactly one more cycle. Only fetches counted after that second clear enter the score.
- R8: At the end of the search, `done_o` is high for exactly one cycle. In that cycle `cfg_o` equals `result_o`, which holds the best setting, and `cost_o` holds its score. Both hold until the next accepted start, and `busy_o` is low on the following cycle.
- R9: `start_i` is accepted only while the block is idle. A start pulse during a search does not change the measured sequence, the result, or the number of `done_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search when idle |
| window_i | input | CNT_W | Fetches scored per candidate |
| warmup_i | input | CNT_W | Fetches ignored after each setting change |
| hit_wt_i | input | WT_W | Weight of one hit |
| miss_wt_i | input | WT_W | Weight of one miss |
| hit_cnt_i | input | CNT_W | Cache hit counter |
| miss_cnt_i | input | CNT_W | Cache miss counter |
| cfg_o | output | 6 | Setting driven to the cache |
| cnt_clr_o | output | 1 | Clear request to the cache counters |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 6 | Best setting found |
| cost_o | output | CNT_W+WT_W+1 | Score of the best setting |

## Verification
The bench uses the default widths: 16-bit counters and 8-bit weights. With these widths, windows of a few dozen fetches and miss weights up to 100 give scores that differ between candidates, so the winner moves between capacities and line lengths from one table row to the next. In the bench's cache model, the miss rate is a function of the applied setting. This lets the bench cover runs that finish at 2 KB, where every multi-way candidate must be skipped, as well as runs that finish at larger sizes. An equal-weight run makes every score tie, which pins the result to the starting setting.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
  localparam int CFG_W    = 6;
  localparam int LAST_IDX = 2;

  typedef enum logic [1:0] {PH_SIZE = 2'd0, PH_LINE = 2'd1, PH_WAYS = 2'd2} phase_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_APPLY, ST_WARM, ST_MEAS, ST_STEP, ST_DONE
  } state_e;

  typedef struct packed {
    logic [1:0] ways;
    logic [1:0] line;
    logic [1:0] size;
  } cfg_t;

  // a way occupies at least one 2 KB bank
  function automatic logic cfg_ok(cfg_t c);
    return (c.ways <= c.size) && (c.size <= 2'd2) && (c.line <= 2'd2);
  endfunction
endpackage

// File: rtl/tuner_step.sv
module tuner_step
  import tuner_pkg::*;
(
  input  phase_e     phase_i,
  input  logic [1:0] idx_i,
  input  cfg_t       best_i,
  output phase_e     phase_o,
  output logic [1:0] idx_o,
  output cfg_t       cfg_o,
  output logic       measure_o,
  output logic       last_o
);
  always_comb begin
    last_o  = (phase_i == PH_WAYS) && (idx_i == 2'(LAST_IDX));
    phase_o = phase_i;
    idx_o   = idx_i + 2'd1;
    if (idx_i == 2'(LAST_IDX)) begin
      idx_o   = 2'd0;
      phase_o = (phase_i == PH_SIZE) ? PH_LINE : PH_WAYS;
    end
    cfg_o = best_i;
    case (phase_o)
      PH_SIZE: cfg_o.size = idx_o;
      PH_LINE: cfg_o.line = idx_o;
      default: cfg_o.ways = idx_o;
    endcase
    // index 0 of later passes was already scored in the previous pass
    measure_o = !last_o && cfg_ok(cfg_o) && ((phase_o == PH_SIZE) || (idx_o != 2'd0));
  end
endmodule

// File: rtl/tuner_cost.sv
module tuner_cost #(
  parameter int CNT_W = 16,
  parameter int WT_W  = 8
) (
  input  logic [CNT_W-1:0]      hit_i,
  input  logic [CNT_W-1:0]      miss_i,
  input  logic [WT_W-1:0]       hit_wt_i,
  input  logic [WT_W-1:0]       miss_wt_i,
  input  logic [CNT_W-1:0]      warmup_i,
  input  logic [CNT_W-1:0]      window_i,
  output logic [CNT_W+WT_W:0]   cost_o,
  output logic                  warm_done_o,
  output logic                  win_done_o
);
  localparam int COST_W = CNT_W + WT_W + 1;
  localparam int SUM_W  = CNT_W + 1;

  logic [SUM_W-1:0]  sum;
  logic [COST_W-1:0] hit_part, miss_part;

  always_comb begin
    sum         = SUM_W'(hit_i) + SUM_W'(miss_i);
    warm_done_o = sum >= SUM_W'(warmup_i);
    win_done_o  = sum >= SUM_W'(window_i);
    hit_part    = COST_W'(hit_i) * COST_W'(hit_wt_i);
    miss_part   = COST_W'(miss_i) * COST_W'(miss_wt_i);
    cost_o      = hit_part + miss_part;
  end
endmodule

// File: rtl/cache_tuner.sv
module cache_tuner
  import tuner_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WT_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [CNT_W-1:0]       window_i,
  input  logic [CNT_W-1:0]       warmup_i,
  input  logic [WT_W-1:0]        hit_wt_i,
  input  logic [WT_W-1:0]        miss_wt_i,
  input  logic [CNT_W-1:0]       hit_cnt_i,
  input  logic [CNT_W-1:0]       miss_cnt_i,
  output logic [CFG_W-1:0]       cfg_o,
  output logic                   cnt_clr_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [CFG_W-1:0]       result_o,
  output logic [CNT_W+WT_W:0]    cost_o
);
  localparam int COST_W = CNT_W + WT_W + 1;

  state_e            state_q, state_d;
  phase_e            phase_q, phase_d;
  logic [1:0]        idx_q, idx_d;
  cfg_t              cand_q, cand_d, best_q, best_d, res_q, res_d;
  logic [COST_W-1:0] best_cost_q, best_cost_d, cost_q, cost_d;
  logic              have_q, have_d;

  phase_e            nx_phase;
  logic [1:0]        nx_idx;
  cfg_t              nx_cfg;
  logic              nx_measure, nx_last;
  logic [COST_W-1:0] cand_cost;
  logic              warm_done, win_done;
  logic              clr;

  tuner_step u_step (
    .phase_i  (phase_q),
    .idx_i    (idx_q),
    .best_i   (best_q),
    .phase_o  (nx_phase),
    .idx_o    (nx_idx),
    .cfg_o    (nx_cfg),
    .measure_o(nx_measure),
    .last_o   (nx_last)
  );

  tuner_cost #(.CNT_W(CNT_W), .WT_W(WT_W)) u_cost (
    .hit_i      (hit_cnt_i),
    .miss_i     (miss_cnt_i),
    .hit_wt_i   (hit_wt_i),
    .miss_wt_i  (miss_wt_i),
    .warmup_i   (warmup_i),
    .window_i   (window_i),
    .cost_o     (cand_cost),
    .warm_done_o(warm_done),
    .win_done_o (win_done)
  );

  always_comb begin
    state_d     = state_q;
    phase_d     = phase_q;
    idx_d       = idx_q;
    cand_d      = cand_q;
    best_d      = best_q;
    best_cost_d = best_cost_q;
    have_d      = have_q;
    res_d       = res_q;
    cost_d      = cost_q;
    clr         = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        phase_d = PH_SIZE;
        idx_d   = 2'd0;
        cand_d  = '0;
        have_d  = 1'b0;
        state_d = ST_APPLY;
      end
      ST_APPLY: begin
        clr     = 1'b1;
        state_d = ST_WARM;
      end
      ST_WARM: if (warm_done) begin
        clr     = 1'b1;
        state_d = ST_MEAS;
      end
      ST_MEAS: if (win_done) begin
        if (!have_q || (cand_cost < best_cost_q)) begin
          best_cost_d = cand_cost;
          best_d      = cand_q;
          have_d      = 1'b1;
        end
        state_d = ST_STEP;
      end
      ST_STEP: begin
        if (nx_last) begin
          cand_d  = best_q;
          res_d   = best_q;
          cost_d  = best_cost_q;
          state_d = ST_DONE;
        end else begin
          phase_d = nx_phase;
          idx_d   = nx_idx;
          if (nx_measure) begin
            cand_d  = nx_cfg;
            state_d = ST_APPLY;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_SIZE;
      idx_q       <= '0;
      cand_q      <= '0;
      best_q      <= '0;
      best_cost_q <= '0;
      have_q      <= 1'b0;
      res_q       <= '0;
      cost_q      <= '0;
    end else begin
      state_q     <= state_d;
      phase_q     <= phase_d;
      idx_q       <= idx_d;
      cand_q      <= cand_d;
      best_q      <= best_d;
      best_cost_q <= best_cost_d;
      have_q      <= have_d;
      res_q       <= res_d;
      cost_q      <= cost_d;
    end
  end

  assign cfg_o     = cand_q;
  assign cnt_clr_o = clr;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign result_o  = res_q;
  assign cost_o    = cost_q;
endmodule

// File: rtl/tuner_chk.sv
module tuner_chk
  import tuner_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             cnt_clr_o,
  input logic [CFG_W-1:0] cfg_o,
  input logic [CFG_W-1:0] result_o
);
  a_r1_idle_holds_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(cfg_o));

  a_r4_cfg_realisable: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cfg_o[5:4] <= cfg_o[1:0]));

  a_r7_clr_in_search: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_o |-> (busy_o && !done_o));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  a_r8_result_applied: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cfg_o == result_o));

  a_r9_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind cache_tuner tuner_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .cnt_clr_o(cnt_clr_o),
  .cfg_o    (cfg_o),
  .result_o (result_o)
);

// File: tb/tb_cache_tuner.sv
module tb_cache_tuner;
  localparam int CNT_W  = 16;
  localparam int WT_W   = 8;
  localparam int COST_W = CNT_W + WT_W + 1;
  localparam int ROWS   = 5;
  localparam int WDOG   = 150000;

  // seed[55:48] window[47:32] warmup[31:16] hit_wt[15:8] miss_wt[7:0]
  localparam logic [55:0] VEC [ROWS] = '{
    {8'd0, 16'd40, 16'd5,  8'd1, 8'd20},
    {8'd3, 16'd33, 16'd0,  8'd2, 8'd50},
    {8'd5, 16'd64, 16'd12, 8'd0, 8'd7},
    {8'd1, 16'd17, 16'd3,  8'd5, 8'd9},
    {8'd4, 16'd50, 16'd8,  8'd1, 8'd100}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [CNT_W-1:0] window, warmup, hit_cnt, miss_cnt;
  logic [WT_W-1:0]  hit_wt, miss_wt;
  logic [5:0]       cfg, result;
  logic             clr, busy, done;
  logic [COST_W-1:0] cost;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  int clr_seen, done_seen, n_got;
  logic [5:0] got_seq [8];
  logic [7:0] seed;
  logic       logging;

  always #5 clk = ~clk;

  cache_tuner #(.CNT_W(CNT_W), .WT_W(WT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .window_i(window), .warmup_i(warmup),
    .hit_wt_i(hit_wt), .miss_wt_i(miss_wt), .hit_cnt_i(hit_cnt), .miss_cnt_i(miss_cnt),
    .cfg_o(cfg), .cnt_clr_o(clr), .busy_o(busy), .done_o(done),
    .result_o(result), .cost_o(cost)
  );

  function automatic int period(logic [5:0] c, logic [7:0] s);
    return 2 + ((int'(c[1:0]) * 7 + int'(c[3:2]) * 3 + int'(c[5:4]) * 5 + int'(s)) % 6);
  endfunction

  // cache model: one fetch per cycle, miss on every period-th fetch after a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_cnt  <= '0;
      miss_cnt <= '0;
    end else if (clr) begin
      hit_cnt  <= '0;
      miss_cnt <= '0;
    end else if (((int'(hit_cnt) + int'(miss_cnt)) % period(cfg, seed)) == 0) begin
      miss_cnt <= miss_cnt + 1'b1;
    end else begin
      hit_cnt <= hit_cnt + 1'b1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (logging) begin
      if (clr) begin
        if ((clr_seen % 2) == 0 && n_got < 8) begin
          got_seq[n_got] = cfg;
          n_got++;
        end
        clr_seen++;
      end
      if (done) done_seen++;
    end
    if (cycles > WDOG) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
      $finish;
    end
  end

  task automatic check(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint score(logic [5:0] c, logic [7:0] s, int n, int hw, int mw);
    int p = period(c, s);
    int m = (n + p - 1) / p;
    return longint'(n - m) * hw + longint'(m) * mw;
  endfunction

  // greedy reference built from R2..R6
  task automatic model(input logic [7:0] s, input int n, input int hw, input int mw,
                       output logic [5:0] bc, output longint bcost,
                       output logic [5:0] seq [8], output int nm);
    logic [5:0] c;
    longint v;
    bc = 6'd0; bcost = score(6'd0, s, n, hw, mw); seq[0] = 6'd0; nm = 1;
    for (int k = 1; k < 3; k++) begin
      c = {2'd0, 2'd0, 2'(k)};
      v = score(c, s, n, hw, mw); seq[nm] = c; nm++;
      if (v < bcost) begin bcost = v; bc = c; end
    end
    for (int k = 1; k < 3; k++) begin
      c = {2'd0, 2'(k), bc[1:0]};
      v = score(c, s, n, hw, mw); seq[nm] = c; nm++;
      if (v < bcost) begin bcost = v; bc = c; end
    end
    for (int k = 1; k < 3; k++) begin
      c = {2'(k), bc[3:2], bc[1:0]};
      if (k <= int'(bc[1:0])) begin
        v = score(c, s, n, hw, mw); seq[nm] = c; nm++;
        if (v < bcost) begin bcost = v; bc = c; end
      end
    end
  endtask

  task automatic run(input logic [7:0] s, input int n, input int w, input int hw,
                     input int mw, input bit poke);
    logic [5:0] ebc;
    longint     ecost;
    logic [5:0] eseq [8];
    int         enm, seq_bad;
    model(s, n, hw, mw, ebc, ecost, eseq, enm);
    seed = s; window = CNT_W'(n); warmup = CNT_W'(w);
    hit_wt = WT_W'(hw); miss_wt = WT_W'(mw);
    clr_seen = 0; done_seen = 0; n_got = 0; logging = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (n + w + 6) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (done_seen == 0) @(negedge clk);
    check("R8 cfg equals result at done", longint'(cfg), longint'(result));
    repeat (4) @(negedge clk);
    logging = 1'b0;
    check("R8 single done pulse", done_seen, 1);
    check("R8 busy low after done", longint'(busy), 0);
    check("R6 best setting", longint'(result), longint'(ebc));
    check("R5 best score", longint'(cost), ecost);
    check("R8 cfg holds best", longint'(cfg), longint'(ebc));
    check("R4 measured count", clr_seen / 2, enm);
    seq_bad = 0;
    for (int i = 0; i < enm && i < 8; i++) if (got_seq[i] !== eseq[i]) seq_bad++;
    check("R2 R3 R4 order of candidates", seq_bad, 0);
    if (poke) check("R9 start ignored during search", clr_seen / 2, enm);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; logging = 1'b0; seed = '0;
    window = '0; warmup = '0; hit_wt = '0; miss_wt = '0;
    clr_seen = 0; done_seen = 0; n_got = 0;
    repeat (3) @(negedge clk);
    check("R1 cfg at reset", longint'(cfg), 0);
    check("R1 busy at reset", longint'(busy), 0);
    check("R1 done at reset", longint'(done), 0);
    check("R1 clr at reset", longint'(clr), 0);
    check("R1 result at reset", longint'(result), 0);
    check("R1 cost at reset", longint'(cost), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", longint'(busy), 0);

    for (int r = 0; r < ROWS; r++)
      run(VEC[r][55:48], int'(VEC[r][47:32]), int'(VEC[r][31:16]),
          int'(VEC[r][15:8]), int'(VEC[r][7:0]), 1'b0);

    // R6: equal weights tie every score, start setting kept; R4: all multi-way skipped
    run(8'd2, 30, 2, 3, 3, 1'b0);
    check("R6 tie keeps start setting", longint'(result), 0);
    check("R4 ways skipped at 2 KB", clr_seen / 2, 5);

    // R9: extra start while measuring
    run(VEC[0][55:48], int'(VEC[0][47:32]), int'(VEC[0][31:16]),
        int'(VEC[0][15:8]), int'(VEC[0][7:0]), 1'b1);

    // R7: long warm-up must not leak into the score
    run(8'd3, 20, 45, 4, 60, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule